// File: doc/BRIEF.md
# Dual-Protocol Multiplexed Bus Slave Interface

This block is the slave end of an 8-bit bus that carries address and data over the same lines. It sits in front of a 128-entry byte register file. A strap input selects one of two strobe schemes. In the split-strobe scheme there is an address-latch strobe and separate active-low read and write strobes. In the direction-strobe scheme there is an address strobe, an active-high data strobe and a read/write direction line. Every bus input is brought into the system clock domain through a two-flop synchronizer. Edges are found only after that point.

On the falling edge of the address strobe the block keeps the low seven bits of the bus as the register-file address. Each data phase then turns into a one-cycle read request or a one-cycle write request. Read data leaves on a data-out bus with an output enable, and the pad cell outside the block combines them. A power-good input, synchronized like the strobes, suppresses every read, write and bus drive while it is low.

Top module: `mbus_slave_if`

## Requirements
- R1: While reset is asserted, `rf_rd_o`, `rf_wr_o` and `ad_oe_o` are low and `rf_addr_o` is zero.
- R2: When the synchronized address strobe goes from high to low, `rf_addr_o` takes bits 6:0 of `ad_i` from the last sample in which the strobe was high. This happens on the second clock edge after the edge that first samples the strobe low. Bit 7 is not part of the address. `rf_addr_o` changes at no other time.
- R3: With `mode_sel_i` = 0, a data phase lasts while `dstb_i` (active-low read) or `dir_i` (active-low write) is low. The phase is a read when `dstb_i` is low.
- R4: With `mode_sel_i` = 1, a data phase lasts while `dstb_i` is high. The phase is a read when `dir_i` is 1 and a write when `dir_i` is 0.
- R5: Each read data phase produces exactly one `rf_rd_o` pulse, one clock cycle long, in its first synchronized cycle.
- R6: `ad_oe_o` is high for every synchronized cycle of a read data phase and low in the first cycle after it ends. `ad_o` equals `rf_rdata_i` while `ad_oe_o` is high and is zero otherwise.
- R7: Each write data phase produces exactly one `rf_wr_o` pulse, one clock cycle long, in the first synchronized cycle after the phase ends. `rf_wdata_o` then holds the bus value of the last synchronized cycle inside the phase.
- R8: While synchronized `pwr_ok_i` is low, no read request, write request or output enable is issued.
- R9: If a write phase ends in the same sampled cycle as the address strobe falls, the write goes to the previously latched address. The new address takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Strobe scheme strap: 0 split strobes, 1 data strobe plus direction |
| pwr_ok_i | input | 1 | Supply-good indication, low blocks accesses |
| addr_stb_i | input | 1 | Address strobe, falling edge latches address |
| dstb_i | input | 1 | Mode 0: read strobe, active low. Mode 1: data strobe, active high |
| dir_i | input | 1 | Mode 0: write strobe, active low. Mode 1: direction, 1 read / 0 write |
| ad_i | input | 8 | Multiplexed address/data bus, input side |
| ad_o | output | 8 | Read data towards the pad |
| ad_oe_o | output | 1 | Pad output enable |
| rf_addr_o | output | 7 | Latched register-file address |
| rf_rd_o | output | 1 | One-cycle read request |
| rf_wr_o | output | 1 | One-cycle write request |
| rf_wdata_o | output | 8 | Write data for the register file |
| rf_rdata_i | input | 8 | Register-file read data for `rf_addr_o` |

## Verification
The address capture and the write commit can fall into the same clock cycle. When that happens, the latched address must not move under the write. The bench provokes this in split-strobe mode. During a write phase it raises the address strobe again, and then releases the write strobe and drops the address strobe at the same clock edge. The bus value is chosen so that it is both the write data and a new address. The bench model and a later read-back of both locations show whether the byte landed at the old address and the other location stayed untouched.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic {
    MODE_SPLIT_STB = 1'b0,
    MODE_DIR_STB   = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic phase;
    logic is_read;
  } access_s;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
(
  input  bus_mode_e mode_i,
  input  logic      dstb_i,
  input  logic      dir_i,
  output access_s   acc_o
);

  always_comb begin
    case (mode_i)
      MODE_DIR_STB: begin
        acc_o.phase   = dstb_i;
        acc_o.is_read = dir_i;
      end
      default: begin
        acc_o.phase   = ~dstb_i | ~dir_i;
        acc_o.is_read = ~dstb_i;
      end
    endcase
  end

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fall_o
);

  logic              stb_q;
  logic [ADDR_W-1:0] ad_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  assign fall_o = stb_q & ~stb_i;

  always_comb begin
    addr_d = addr_q;
    if (fall_o) addr_d = ad_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      ad_q   <= '0;
      addr_q <= '0;
    end else begin
      stb_q  <= stb_i;
      ad_q   <= ad_i;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if
  import mbus_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_sel_i,
  input  logic              pwr_ok_i,
  input  logic              addr_stb_i,
  input  logic              dstb_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic              rf_rd_o,
  output logic              rf_wr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);

  localparam int CTRL_W = 4;
  localparam int SYNC_W = DATA_W + CTRL_W;

  bus_mode_e         mode;
  logic [SYNC_W-1:0] sync_q;
  logic              pwr_s, stb_s, dstb_s, dir_s;
  logic [DATA_W-1:0] ad_s;
  access_s           acc, acc_q;
  logic              addr_fall;
  logic              ph_start, ph_end;
  logic [DATA_W-1:0] wcap_q, wcap_d;

  assign mode = bus_mode_e'(mode_sel_i);

  mbus_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_ok_i, addr_stb_i, dstb_i, dir_i, ad_i}),
    .q_o    (sync_q)
  );

  assign {pwr_s, stb_s, dstb_s, dir_s, ad_s} = sync_q;

  mbus_decode u_dec (
    .mode_i (mode),
    .dstb_i (dstb_s),
    .dir_i  (dir_s),
    .acc_o  (acc)
  );

  mbus_addr_latch #(
    .ADDR_W (ADDR_W)
  ) u_alat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb_s),
    .ad_i   (ad_s[ADDR_W-1:0]),
    .addr_o (rf_addr_o),
    .fall_o (addr_fall)
  );

  assign ph_start = acc.phase & ~acc_q.phase;
  assign ph_end   = acc_q.phase & ~acc.phase;

  always_comb begin
    wcap_d = wcap_q;
    if (acc.phase && !acc.is_read) wcap_d = ad_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      wcap_q <= '0;
    end else begin
      acc_q  <= acc;
      wcap_q <= wcap_d;
    end
  end

  assign rf_rd_o    = ph_start & acc.is_read & pwr_s;
  assign rf_wr_o    = ph_end & ~acc_q.is_read & pwr_s;
  assign ad_oe_o    = acc.phase & acc.is_read & pwr_s;
  assign ad_o       = ad_oe_o ? rf_rdata_i : '0;
  assign rf_wdata_o = wcap_q;

  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_o |=> !rf_rd_o); // R5
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_o |=> !rf_wr_o); // R7
  AST_RD_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_o |-> ad_oe_o); // R6
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_end |-> !ad_oe_o); // R6
  AST_OE_NOT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !rf_wr_o); // R6
  AST_PWR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_s |-> !(rf_rd_o || rf_wr_o || ad_oe_o)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_fall |=> $stable(rf_addr_o)); // R2

endmodule

// File: tb/mbus_slave_if_tb_top.sv
`timescale 1ns/1ps
module mbus_slave_if_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_sel, pwr_ok, addr_stb, dstb, dir;
  logic [7:0] ad_in, ad_out, rf_wdata, rf_rdata;
  logic       ad_oe, rf_rd, rf_wr;
  logic [6:0] rf_addr;

  always #4 clk = ~clk;

  logic [7:0] mem [128];
  assign rf_rdata = mem[rf_addr];

  mbus_slave_if dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_sel_i (mode_sel),
    .pwr_ok_i   (pwr_ok),
    .addr_stb_i (addr_stb),
    .dstb_i     (dstb),
    .dir_i      (dir),
    .ad_i       (ad_in),
    .ad_o       (ad_out),
    .ad_oe_o    (ad_oe),
    .rf_addr_o  (rf_addr),
    .rf_rd_o    (rf_rd),
    .rf_wr_o    (rf_wr),
    .rf_wdata_o (rf_wdata),
    .rf_rdata_i (rf_rdata)
  );

  typedef struct packed {
    logic       pg;
    logic       stb;
    logic       ds;
    logic       dr;
    logic [7:0] ad;
  } snap_t;

  snap_t      hist [4];
  logic [6:0] m_addr;
  logic       exp_wr;
  logic [6:0] exp_addr;
  logic [7:0] exp_wd;
  int         checks = 0, failures = 0;
  int         rd_cnt, wr_cnt, oe_cnt;
  logic [7:0] last_val;
  bit         done = 0;

  function automatic logic ph_of(snap_t s);
    return mode_sel ? s.ds : (!s.ds || !s.dr);
  endfunction

  function automatic logic rd_of(snap_t s);
    return mode_sel ? s.dr : !s.ds;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: input history plus latched-address model
  always @(posedge clk) begin
    logic e_ph, e_phd, e_rd, e_rdd, e_pg, e_rq, e_oe, e_wr;
    if (exp_wr) mem[exp_addr] = exp_wd;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = '0;
      m_addr = '0;
      exp_wr = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {pwr_ok, addr_stb, dstb, dir, ad_in};
      if (hist[3].stb && !hist[2].stb) m_addr = hist[3].ad[6:0];
    end
    #2;
    if (rst_n && !done) begin
      e_ph  = ph_of(hist[1]);
      e_phd = ph_of(hist[2]);
      e_rd  = rd_of(hist[1]);
      e_rdd = rd_of(hist[2]);
      e_pg  = hist[1].pg;
      e_rq  = e_ph && !e_phd && e_rd && e_pg;
      e_oe  = e_ph && e_rd && e_pg;
      e_wr  = e_phd && !e_ph && !e_rdd && e_pg;
      check("R5 read request", int'(rf_rd), int'(e_rq));
      check("R6 output enable", int'(ad_oe), int'(e_oe));
      check("R6 data out", int'(ad_out), e_oe ? int'(mem[m_addr]) : 0);
      check("R7 write request", int'(rf_wr), int'(e_wr));
      check("R2 latched address", int'(rf_addr), int'(m_addr));
      if (e_wr) check("R7 write data", int'(rf_wdata), int'(hist[2].ad));
      exp_wr   = e_wr;
      exp_addr = m_addr;
      exp_wd   = hist[2].ad;
      rd_cnt  += int'(rf_rd);
      wr_cnt  += int'(rf_wr);
      if (ad_oe) begin
        oe_cnt++;
        last_val = ad_out;
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_idle();
    addr_stb = 1'b0;
    ad_in    = 8'h00;
    dstb     = mode_sel ? 1'b0 : 1'b1;
    dir      = 1'b1;
  endtask

  task automatic do_reset(input logic m, input bit chk);
    @(negedge clk);
    rst_n    = 1'b0;
    mode_sel = m;
    pwr_ok   = 1'b1;
    set_idle();
    wait_n(3);
    if (chk) begin
      check("R1 reset rd", int'(rf_rd), 0);
      check("R1 reset wr", int'(rf_wr), 0);
      check("R1 reset oe", int'(ad_oe), 0);
      check("R1 reset addr", int'(rf_addr), 0);
    end
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    ad_in = a; addr_stb = 1'b1;
    wait_n(3);
    addr_stb = 1'b0;
    wait_n(2);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    wr_cnt = 0;
    addr_phase(a);
    if (mode_sel) begin
      dir = 1'b0; ad_in = d; wait_n(1);
      dstb = 1'b1; wait_n(4);
      dstb = 1'b0; wait_n(2);
      dir = 1'b1;
    end else begin
      ad_in = d; dir = 1'b0; wait_n(4);
      dir = 1'b1; wait_n(3);
    end
    ad_in = 8'h00;
    wait_n(3);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    rd_cnt = 0; oe_cnt = 0; last_val = 8'hxx;
    addr_phase(a);
    ad_in = 8'h00;
    if (mode_sel) begin
      dir = 1'b1; dstb = 1'b1; wait_n(5);
      dstb = 1'b0;
    end else begin
      dstb = 1'b0; wait_n(5);
      dstb = 1'b1;
    end
    wait_n(4);
    v = last_val;
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h3C;
    exp_wr = 1'b0;
    rst_n = 1'b0; mode_sel = 1'b0; pwr_ok = 1'b1;
    set_idle();

    // Split-strobe mode
    do_reset(1'b0, 1);
    bus_write(8'h23, 8'h5A);
    check("R7 one write pulse", wr_cnt, 1);
    bus_read(8'h23, v);
    check("R3 split-mode read-back", int'(v), 8'h5A);
    check("R5 one read pulse", rd_cnt, 1);
    bus_write(8'hA3, 8'h77);
    bus_read(8'h23, v);
    check("R2 bit7 outside address", int'(v), 8'h77);

    // Supply gate
    pwr_ok = 1'b0;
    wait_n(3);
    bus_write(8'h23, 8'h00);
    check("R8 no write while unpowered", wr_cnt, 0);
    bus_read(8'h23, v);
    check("R8 no drive while unpowered", oe_cnt, 0);
    pwr_ok = 1'b1;
    wait_n(3);
    bus_read(8'h23, v);
    check("R8 location untouched", int'(v), 8'h77);

    // Address fall coinciding with write end
    bus_read(8'h12, v);
    wr_cnt = 0;
    ad_in = 8'hC5; dir = 1'b0;
    wait_n(2);
    addr_stb = 1'b1;
    wait_n(2);
    addr_stb = 1'b0; dir = 1'b1;
    wait_n(4);
    ad_in = 8'h00;
    wait_n(2);
    check("R9 single write", wr_cnt, 1);
    check("R9 new address after write", int'(rf_addr), 8'h45);
    bus_read(8'h12, v);
    check("R9 write hit old address", int'(v), 8'hC5);
    bus_read(8'h45, v);
    check("R9 new address untouched", int'(v), 8'h45 ^ 8'h3C);

    // Direction-strobe mode
    do_reset(1'b1, 1);
    bus_write(8'h40, 8'h9E);
    check("R4 one write pulse", wr_cnt, 1);
    bus_read(8'h40, v);
    check("R4 direction-mode read-back", int'(v), 8'h9E);
    check("R5 one read pulse", rd_cnt, 1);
    check("R6 enable held over phase", int'(oe_cnt >= 4), 1);
    bus_write(8'h7F, 8'h01);
    bus_read(8'h7F, v);
    check("R4 top address", int'(v), 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule